// File: doc/BRIEF.md
# Multiplexed External SRAM Bridge

This block connects the data-memory request side of an 8-bit processor to an asynchronous external SRAM. The external bus has two 8-bit pin groups. The first group carries the low address byte and then the data byte, so it needs an external address latch. The second group carries the high address byte. A small control register holds an enable bit and a wait-state bit. While the enable bit is set, the bridge takes over both pin groups regardless of their general-purpose direction settings. While it is clear, the pins follow their general-purpose output and direction values.

The processor raises `req` for one cycle with an address, a read/write select and write data. Only addresses above the top of internal data memory start an external cycle; lower addresses are served elsewhere and leave the bus untouched. The bridge steps through a fixed sequence of states and then raises a one-cycle `rsp_done`; on a read, `rsp_rdata` is valid in that same cycle.

The states are IDLE, ADDR, STROBE, WAIT and FINISH. The transitions are:
- accept: IDLE to ADDR, when the bridge is enabled, `req` is high and the address is external.
- latch: ADDR to STROBE, always.
- stretch: STROBE to WAIT, when the wait bit was set at accept.
- close: STROBE to FINISH (no wait) or WAIT to FINISH.
- release: FINISH to IDLE, always.

Top module: `xmem_bridge`

## Requirements
- R1: Out of reset, both control bits are 0. The pins then follow the general-purpose values (`pa_out`=`gpa_out`, `pa_oe`=`gpa_dir`, `pc_out`=`gpc_out`, `pc_oe`=`gpc_dir`), `ale` is 0, `rd_n` and `wr_n` are 1, and `rsp_done` is 0.
- R2: While the enable bit is 0, the pins keep following the general-purpose values and requests are ignored: no `ale` pulse and no `rsp_done`.
- R3: While the enable bit is 1, both pin groups are driven by the bridge whatever the direction settings are. In IDLE, `pa_oe` is 0x00 and `pc_oe` is 0xFF.
- R4: In the first access cycle (ADDR), `ale` is 1, `pa_out` is the address bits 7:0 and `pa_oe` is 0xFF. Throughout the access, `pc_out` is the address bits 15:8 and `pc_oe` is 0xFF.
- R5: `rsp_done` is high in the last access cycle. An access lasts 3 cycles (ADDR, STROBE, FINISH) when the wait bit is 0, and 4 cycles (ADDR, STROBE, WAIT, FINISH) when it is 1.
- R6: On a read, `rd_n` is 0 and `pa_oe` is 0x00 in every strobe cycle. `rsp_rdata` is `pa_in` as sampled at the close of the last strobe cycle, and it is presented while `rsp_done` is high.
- R7: On a write, `wr_n` is 0 in every strobe cycle. In the strobe cycles and in FINISH, `pa_out` holds the write data and `pa_oe` is 0xFF. `wr_n` is already 1 in FINISH, which gives hold time.
- R8: Only addresses greater than INT_TOP (default 0x0FFF) start an access. An address at or below INT_TOP leaves the bus idle and gives no `rsp_done`.
- R9: `rsp_done` lasts exactly one cycle. A `req` that arrives while an access is in progress is ignored.
- R10: Outside an access, `ale` is 0 and both strobes are 1. `rd_n` and `wr_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_en_in | input | 1 | New enable bit |
| ctl_wait_in | input | 1 | New wait-state bit |
| req | input | 1 | Access request, one cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_rdata | output | 8 | Read data |
| rsp_done | output | 1 | Access complete, one cycle |
| gpa_out | input | 8 | General-purpose output value, low group |
| gpa_dir | input | 8 | General-purpose direction, low group (1 = drive) |
| gpc_out | input | 8 | General-purpose output value, high group |
| gpc_dir | input | 8 | General-purpose direction, high group |
| pa_in | input | 8 | Low group pin input |
| pa_out | output | 8 | Low group pin output value |
| pa_oe | output | 8 | Low group pin drive enable |
| pc_out | output | 8 | High group pin output value |
| pc_oe | output | 8 | High group pin drive enable |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The bench runs reads and writes at both wait settings, including the boundary addresses 0x1000 and 0xFFFF. It counts the cycles up to `rsp_done` and the strobe-low cycles in each access. A design that miscounts would finish after the wrong number of cycles, and one that samples read data in the wrong cycle would return the idle pin value instead of the memory byte. Several corner cases get their own tests:
- Address 0x0FFF and a disabled bridge, where a wrongly decoding design would pulse `ale`.
- A second request during a busy access, which a design without proper acceptance would run as an extra access.
- The write FINISH cycle, where a design that drops the data too early would lose hold time.
- The idle pin drive, which must ignore the direction settings.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_STROBE,
        XS_WAIT,
        XS_FINISH
    } xstate_t;
endpackage

// File: rtl/xmem_ctl_reg.sv
module xmem_ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we,
    input  logic ctl_en_in,
    input  logic ctl_wait_in,
    output logic en_q,
    output logic wait_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            wait_q <= 1'b0;
        end else if (ctl_we) begin
            en_q   <= ctl_en_in;
            wait_q <= ctl_wait_in;
        end
    end
endmodule

// File: rtl/xmem_fsm.sv
module xmem_fsm
    import xmem_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] INT_TOP = 16'h0FFF,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wt,
    input  logic          req,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] bus_in,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n,
    output logic          lo_oe,
    output logic [DW-1:0] lo_out,
    output logic [HW-1:0] hi_out,
    output logic          done,
    output logic [DW-1:0] rdata
);
    xstate_t       state, nstate;
    logic [AW-1:0] addr_l;
    logic [DW-1:0] wdata_l;
    logic          we_l;
    logic          wait_l;
    logic          accept;
    logic          sample;

    assign accept = (state == XS_IDLE) && en && req && (addr > INT_TOP);
    assign sample = !we_l && (((state == XS_STROBE) && !wait_l) || (state == XS_WAIT));

    always_comb begin
        nstate = state;
        unique case (state)
            XS_IDLE:   if (accept) nstate = XS_ADDR;
            XS_ADDR:   nstate = XS_STROBE;
            XS_STROBE: nstate = wait_l ? XS_WAIT : XS_FINISH;
            XS_WAIT:   nstate = XS_FINISH;
            XS_FINISH: nstate = XS_IDLE;
            default:   nstate = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_l  <= '0;
            wdata_l <= '0;
            we_l    <= 1'b0;
            wait_l  <= 1'b0;
            rdata   <= '0;
        end else begin
            if (accept) begin
                addr_l  <= addr;
                wdata_l <= wdata;
                we_l    <= we;
                wait_l  <= wt;
            end
            if (sample) rdata <= bus_in;
        end
    end

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        lo_oe  = 1'b0;
        lo_out = wdata_l;
        done   = 1'b0;
        hi_out = addr_l[AW-1:DW];
        unique case (state)
            XS_IDLE: ;
            XS_ADDR: begin
                ale    = 1'b1;
                lo_oe  = 1'b1;
                lo_out = addr_l[DW-1:0];
            end
            XS_STROBE, XS_WAIT: begin
                rd_n  = we_l;
                wr_n  = !we_l;
                lo_oe = we_l;
            end
            XS_FINISH: begin
                lo_oe = we_l;
                done  = 1'b1;
            end
            default: ;
        endcase
    end

    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!rd_n || !wr_n));
    assert_strobe_after_ale_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(ale));
    assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> lo_oe);
    assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> !lo_oe);
    assert_ext_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> ({hi_out, lo_out} > INT_TOP));
endmodule

// File: rtl/xmem_pinmux.sv
module xmem_pinmux #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic [W-1:0] bus_out,
    input  logic         bus_oe,
    input  logic [W-1:0] gp_out,
    input  logic [W-1:0] gp_dir,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign pin_out[i] = en ? bus_out[i] : gp_out[i];
        assign pin_oe[i]  = en ? bus_oe     : gp_dir[i];
    end
endmodule

// File: rtl/xmem_bridge.sv
module xmem_bridge #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [AW-1:0] INT_TOP = 16'h0FFF,
    localparam int HW = AW - DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_en_in,
    input  logic          ctl_wait_in,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    input  logic [DW-1:0] gpa_out,
    input  logic [DW-1:0] gpa_dir,
    input  logic [HW-1:0] gpc_out,
    input  logic [HW-1:0] gpc_dir,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    output logic [HW-1:0] pc_out,
    output logic [HW-1:0] pc_oe,
    output logic          ale,
    output logic          rd_n,
    output logic          wr_n
);
    logic          en_q, wait_q;
    logic          lo_oe;
    logic [DW-1:0] lo_out;
    logic [HW-1:0] hi_out;

    xmem_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_en_in(ctl_en_in),
        .ctl_wait_in(ctl_wait_in), .en_q(en_q), .wait_q(wait_q)
    );

    xmem_fsm #(.AW(AW), .DW(DW), .INT_TOP(INT_TOP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .wt(wait_q), .req(req),
        .we(req_we), .addr(req_addr), .wdata(req_wdata), .bus_in(pa_in),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .lo_oe(lo_oe), .lo_out(lo_out),
        .hi_out(hi_out), .done(rsp_done), .rdata(rsp_rdata)
    );

    xmem_pinmux #(.W(DW)) u_mux_a (
        .en(en_q), .bus_out(lo_out), .bus_oe(lo_oe), .gp_out(gpa_out),
        .gp_dir(gpa_dir), .pin_out(pa_out), .pin_oe(pa_oe)
    );

    xmem_pinmux #(.W(HW)) u_mux_c (
        .en(en_q), .bus_out(hi_out), .bus_oe(1'b1), .gp_out(gpc_out),
        .gp_dir(gpc_dir), .pin_out(pc_out), .pin_oe(pc_oe)
    );

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> (!ale && !rsp_done));
endmodule

// File: tb/xmem_bridge_test.sv
module xmem_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 0, ctl_en_in = 0, ctl_wait_in = 0;
    logic        req = 0, req_we = 0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [7:0]  gpa_out = 8'h3C, gpa_dir = 8'h0F, gpc_out = 8'hC3, gpc_dir = 8'hF0;
    logic [7:0]  pa_in, pa_out, pa_oe, pc_out, pc_oe;
    logic        ale, rd_n, wr_n;

    int checks = 0, errors = 0, cyc = 0, both_low = 0;
    logic [15:0] lat_addr = '0;

    always #4 clk = ~clk;

    xmem_bridge uut (.*);

    function automatic logic [7:0] mem_val(logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign pa_in = !rd_n ? mem_val(lat_addr) : 8'h00;

    always @(negedge clk) begin
        if (ale) lat_addr = {pc_out, pa_out};
        if (!rd_n && !wr_n) both_low++;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic cfg(input logic en, input logic wt);
        @(negedge clk); ctl_we = 1; ctl_en_in = en; ctl_wait_in = wt;
        @(negedge clk); ctl_we = 0;
    endtask

    task automatic pulse_req(input logic we, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); req = 1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk); req = 0;
    endtask

    task automatic quiet_window(input string tag);
        int seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ale || rsp_done || !rd_n || !wr_n) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic access(input logic we, input logic wt, input logic [15:0] a, input logic [7:0] d);
        int n = 1, strobes = 0, bad = 0;
        pulse_req(we, a, d);
        chk(ale == 1'b1 && pa_oe == 8'hFF, "R4 ale/oe in ADDR", {ale, pa_oe}, 9'h1FF);
        chk(pa_out == a[7:0], "R4 low address", pa_out, a[7:0]);
        chk(pc_out == a[15:8] && pc_oe == 8'hFF, "R4 high address", pc_out, a[15:8]);
        while (!rsp_done && n < 10) begin
            @(negedge clk);
            n++;
            if (pc_out != a[15:8] || ale) bad++;
            if (!rsp_done) begin
                strobes++;
                if (we) begin
                    if (wr_n || !rd_n || pa_oe != 8'hFF || pa_out != d) bad++;
                end else begin
                    if (rd_n || !wr_n || pa_oe != 8'h00) bad++;
                end
            end
        end
        chk(n == (wt ? 4 : 3), "R5 access length", n, wt ? 4 : 3);
        if (we) begin
            chk(bad == 0 && strobes == n - 2, "R7 write strobe phase", bad, 0);
            chk(wr_n && pa_oe == 8'hFF && pa_out == d, "R7 write hold in FINISH", pa_out, d);
        end else begin
            chk(bad == 0 && strobes == n - 2, "R6 read strobe phase", bad, 0);
            chk(rsp_rdata == mem_val(a), "R6 read data", rsp_rdata, mem_val(a));
        end
        @(negedge clk);
        chk(!rsp_done && ale == 0 && rd_n && wr_n, "R9 R10 done single and bus idle",
            {rsp_done, ale, rd_n, wr_n}, 4'b0011);
    endtask

    localparam int NV = 8;
    localparam logic [NV-1:0][25:0] VECS = '{
        {1'b0, 1'b0, 16'h1000, 8'h00},
        {1'b1, 1'b0, 16'h2345, 8'h5A},
        {1'b0, 1'b1, 16'hFFFF, 8'h00},
        {1'b1, 1'b1, 16'h8001, 8'hC7},
        {1'b0, 1'b0, 16'hABCD, 8'h00},
        {1'b1, 1'b0, 16'hFFFF, 8'h81},
        {1'b0, 1'b1, 16'h1234, 8'h00},
        {1'b1, 1'b1, 16'h1000, 8'h3E}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(pa_out == 8'h3C && pa_oe == 8'h0F, "R1 reset low group", {pa_out, pa_oe}, 16'h3C0F);
        chk(pc_out == 8'hC3 && pc_oe == 8'hF0, "R1 reset high group", {pc_out, pc_oe}, 16'hC3F0);
        chk(!ale && rd_n && wr_n && !rsp_done, "R1 reset strobes", {ale, rd_n, wr_n, rsp_done}, 4'b0110);

        pulse_req(1'b0, 16'h4000, 8'h00);
        quiet_window("R2 request ignored while disabled");
        chk(pa_oe == 8'h0F && pc_out == 8'hC3, "R2 pins follow gp", pa_oe, 8'h0F);

        cfg(1'b1, 1'b0);
        gpa_dir = 8'hFF; gpc_dir = 8'h00;
        @(negedge clk);
        chk(pa_oe == 8'h00 && pc_oe == 8'hFF, "R3 idle override", {pa_oe, pc_oe}, 16'h00FF);
        gpa_dir = 8'h00;

        for (int v = 0; v < NV; v++) begin
            cfg(1'b1, VECS[v][24]);
            access(VECS[v][25], VECS[v][24], VECS[v][23:8], VECS[v][7:0]);
        end

        cfg(1'b1, 1'b0);
        pulse_req(1'b0, 16'h0FFF, 8'h00);
        quiet_window("R8 address at INT_TOP ignored");

        pulse_req(1'b0, 16'h5000, 8'h00);
        @(negedge clk);
        req = 1; req_addr = 16'h6000;
        @(negedge clk);
        req = 0;
        chk(rsp_done == 1'b1, "R5 done on third cycle", rsp_done, 1);
        quiet_window("R9 busy request ignored");

        chk(both_low == 0, "R10 strobes never both low", both_low, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule